// File: doc/BRIEF.md
# Sized Integer Execute Unit

This block is the arithmetic and logic datapath for a family of integer instructions: add, subtract, and, or, exclusive-or, compare, negate, not, an immediate-operand group and a short-constant (quick) add/subtract. Each instruction runs at byte, word or long size, and an opcode field selects the size. The block receives the opcode word, an instruction-group code, the value read from the data register named by the opcode, an already-fetched effective-address operand and two 16-bit extension words. Address generation and memory access are handled elsewhere.

One cycle after a start pulse, the block presents a write-back value with a byte-lane mask and a destination select. It also presents a tag, size, result and source for a downstream condition-code evaluator, the running extend flag, and the number of extension bytes the instruction consumed. When the destination is the data register, the write-back value already holds the register's old upper bits, so the register file can write all 32 bits.

Top module: `sie_exec`

## Requirements
- R1: The size field is opcode[7:6]. The code 0 means byte, 1 means word, 2 means long and 3 is illegal. An illegal size raises `err` with `done`. In that case `wb_dest`, `wb_mask`, `wb_data`, `flag_tag`, `flag_size`, `cc_result`, `cc_source` and `ext_bytes` are all 0, and `x_flag` is unchanged.
- R2: For a data-register destination (`wb_dest`=1), `wb_data` replaces only the low 8, 16 or 32 bits, and the remaining bits equal `reg_in`. `wb_mask` has bit i set for each byte lane that was replaced: 0001, 0011 or 1111. For an effective-address destination (`wb_dest`=2), `wb_data` is the sized result, zero-extended.
- R3: For groups add (0), subtract (1), and (2) and or (3), opcode[8]=1 computes ea_in op reg_in and sends the result to the effective address. opcode[8]=0 computes reg_in op ea_in and sends the result to the data register. Exclusive-or (4) always computes ea_in ^ reg_in and sends it to the effective address.
- R4: Quick group (7) uses opcode[11:9] as the constant, with 0 standing for 8. opcode[8]=1 subtracts the constant from ea_in and opcode[8]=0 adds it. The result goes to the effective address.
- R5: When a quick instruction has opcode[5:3]=001, its size is long whatever opcode[7:6] holds, including the code 3.
- R6: Immediate group (6) takes its operand from `ext0[7:0]` at byte size, `ext0` at word size and {`ext0`,`ext1`} at long size. `ext_bytes` is 2 for byte and word and 4 for long. Every other group reports 0.
- R7: In the immediate group, opcode[11:9] selects the operation: 0 or, 1 and, 2 subtract, 3 add, 5 exclusive-or, 6 compare. The operation is applied to ea_in and the immediate. Compare writes nothing and leaves `x_flag` unchanged. The codes 4 and 7 are illegal, with the same effect as in R1.
- R8: Negate (8) writes 0 − ea_in at the selected size to the effective address and tags a subtract. It sets `x_flag` exactly when the sized operand is non-zero.
- R9: Compare (5) computes reg_in − ea_in, tags a subtract, writes nothing and leaves `x_flag` unchanged.
- R10: An add sets `x_flag` when the sized sum is unsigned-less than the sized source. A subtract sets `x_flag` when the sized minuend is unsigned-less than the sized source. `flag_tag` is 2 for add and 3 for subtract. `cc_result` and `cc_source` carry the sized result and source, zero-extended.
- R11: And, or, exclusive-or and not (9) tag logic (`flag_tag`=1) with `cc_source`=0, and leave `x_flag` unchanged. Not writes the sized complement of ea_in to the effective address.
- R12: `done` pulses for exactly one cycle, in the cycle after `start`. All results stay unchanged until the next start.
- R13: The group codes 10 to 15 are illegal, with the same effect as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one instruction; inputs are sampled in this cycle |
| group | input | 4 | Instruction group code (R3–R13) |
| opcode | input | 16 | Opcode word |
| reg_in | input | 32 | Value of the data register named by opcode[11:9] |
| ea_in | input | 32 | Fetched effective-address operand |
| ext0 | input | 16 | First extension word |
| ext1 | input | 16 | Second extension word |
| done | output | 1 | Results valid |
| err | output | 1 | Illegal size, immediate operation or group |
| wb_dest | output | 2 | 0 none, 1 data register, 2 effective address |
| wb_data | output | 32 | Write-back value |
| wb_mask | output | 4 | Byte lanes replaced |
| flag_tag | output | 2 | 0 none, 1 logic, 2 add, 3 subtract |
| flag_size | output | 2 | Size code of the flag evaluation |
| cc_result | output | 32 | Sized result for the flag evaluator |
| cc_source | output | 32 | Sized source for the flag evaluator |
| x_flag | output | 1 | Extend flag |
| ext_bytes | output | 3 | Extension bytes consumed |

## Verification
Size forcing and size checking can act on the same instruction. A quick operation aimed at an address register (opcode[5:3]=001) with size code 3 must be forced to long and must not be reported as illegal. The bench issues that instruction next to a plain add with size code 3, and requires `err` only for the add. Carry-out and lane merging also coincide on a byte add into a data register whose sum overflows 8 bits. The bench checks that `x_flag` is set while `wb_data` keeps bits 31:8 of `reg_in`, comparing against a behavioural model after every instruction.

// File: rtl/sie_pkg.sv
// Shared types and helpers for the sized integer execute unit.
// Assumes a data width that is a multiple of 8 and at least 32 bits.
package sie_pkg;
    localparam int DATA_W = 32;
    localparam int OPC_W  = 16;
    localparam int EXT_W  = 16;
    localparam int GRP_W  = 4;
    localparam int LANES  = DATA_W / 8;
    localparam int FLD_W  = 9;   // opcode bits 11:3 handed to the decoder

    localparam logic [GRP_W-1:0] GRP_ADD   = 4'd0;
    localparam logic [GRP_W-1:0] GRP_SUB   = 4'd1;
    localparam logic [GRP_W-1:0] GRP_AND   = 4'd2;
    localparam logic [GRP_W-1:0] GRP_OR    = 4'd3;
    localparam logic [GRP_W-1:0] GRP_XOR   = 4'd4;
    localparam logic [GRP_W-1:0] GRP_CMP   = 4'd5;
    localparam logic [GRP_W-1:0] GRP_IMM   = 4'd6;
    localparam logic [GRP_W-1:0] GRP_QUICK = 4'd7;
    localparam logic [GRP_W-1:0] GRP_NEG   = 4'd8;
    localparam logic [GRP_W-1:0] GRP_NOT   = 4'd9;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_BAD = 2'd3} size_e;
    typedef enum logic [1:0] {TAG_NONE = 2'd0, TAG_LOGIC = 2'd1, TAG_ADD = 2'd2, TAG_SUB = 2'd3} tag_e;
    typedef enum logic [1:0] {DST_NONE = 2'd0, DST_DREG = 2'd1, DST_EA = 2'd2} dest_e;
    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOT} alu_e;
    typedef enum logic [1:0] {SA_REG, SA_EA, SA_ZERO} asel_e;
    typedef enum logic [1:0] {SB_REG, SB_EA, SB_IMM, SB_QUICK} bsel_e;

    typedef struct packed {
        logic       legal;
        size_e      size;
        alu_e       op;
        asel_e      asel;
        bsel_e      bsel;
        dest_e      dest;
        tag_e       tag;
        logic       x_upd;
        logic [2:0] ext_bytes;
    } ctrl_t;

    // Bit mask covering the operand size.
    function automatic logic [DATA_W-1:0] size_mask(size_e s);
        case (s)
            SZ_BYTE: size_mask = {{(DATA_W-8){1'b0}}, 8'hFF};
            SZ_WORD: size_mask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: size_mask = '1;
        endcase
    endfunction

    // Byte-lane mask covering the operand size.
    function automatic logic [LANES-1:0] lane_mask(size_e s);
        case (s)
            SZ_BYTE: lane_mask = {{(LANES-1){1'b0}}, 1'b1};
            SZ_WORD: lane_mask = {{(LANES-2){1'b0}}, 2'b11};
            default: lane_mask = '1;
        endcase
    endfunction
endpackage

// File: rtl/sie_decode.sv
// Instruction decoder: turns the group code and opcode fields 11:3 into a
// control word (size, operation, operand routing, destination, flag tag,
// extend update, extension length). Illegal encodings yield a cleared word
// with legal=0. Purely combinational.
module sie_decode
    import sie_pkg::*;
(
    input  logic [GRP_W-1:0] group,
    input  logic [FLD_W-1:0] fld,      // opcode[11:3]
    output ctrl_t            ctrl
);
    logic [2:0] sub_op;
    logic       dir_ea;
    logic [1:0] size_fld;
    logic       an_target;

    assign sub_op    = fld[8:6];
    assign dir_ea    = fld[5];
    assign size_fld  = fld[4:3];
    assign an_target = (fld[2:0] == 3'b001);

    // Build the control word per group, then clear it if anything is illegal.
    always_comb begin
        ctrl       = '0;
        ctrl.size  = size_e'(size_fld);
        ctrl.legal = 1'b1;
        case (group)
            GRP_ADD, GRP_SUB, GRP_AND, GRP_OR: begin
                case (group)
                    GRP_ADD: begin ctrl.op = ALU_ADD; ctrl.tag = TAG_ADD;   ctrl.x_upd = 1'b1; end
                    GRP_SUB: begin ctrl.op = ALU_SUB; ctrl.tag = TAG_SUB;   ctrl.x_upd = 1'b1; end
                    GRP_AND: begin ctrl.op = ALU_AND; ctrl.tag = TAG_LOGIC; end
                    default: begin ctrl.op = ALU_OR;  ctrl.tag = TAG_LOGIC; end
                endcase
                ctrl.asel = dir_ea ? SA_EA  : SA_REG;
                ctrl.bsel = dir_ea ? SB_REG : SB_EA;
                ctrl.dest = dir_ea ? DST_EA : DST_DREG;
            end
            GRP_XOR: begin
                ctrl.op   = ALU_XOR;
                ctrl.tag  = TAG_LOGIC;
                ctrl.asel = SA_EA;
                ctrl.bsel = SB_REG;
                ctrl.dest = DST_EA;
            end
            GRP_CMP: begin
                ctrl.op   = ALU_SUB;
                ctrl.tag  = TAG_SUB;
                ctrl.asel = SA_REG;
                ctrl.bsel = SB_EA;
                ctrl.dest = DST_NONE;
            end
            GRP_IMM: begin
                ctrl.asel      = SA_EA;
                ctrl.bsel      = SB_IMM;
                ctrl.dest      = DST_EA;
                ctrl.ext_bytes = (size_fld == 2'd2) ? 3'd4 : 3'd2;
                case (sub_op)
                    3'd0: begin ctrl.op = ALU_OR;  ctrl.tag = TAG_LOGIC; end
                    3'd1: begin ctrl.op = ALU_AND; ctrl.tag = TAG_LOGIC; end
                    3'd2: begin ctrl.op = ALU_SUB; ctrl.tag = TAG_SUB; ctrl.x_upd = 1'b1; end
                    3'd3: begin ctrl.op = ALU_ADD; ctrl.tag = TAG_ADD; ctrl.x_upd = 1'b1; end
                    3'd5: begin ctrl.op = ALU_XOR; ctrl.tag = TAG_LOGIC; end
                    3'd6: begin ctrl.op = ALU_SUB; ctrl.tag = TAG_SUB; ctrl.dest = DST_NONE; end
                    default: ctrl.legal = 1'b0;
                endcase
            end
            GRP_QUICK: begin
                ctrl.op    = dir_ea ? ALU_SUB : ALU_ADD;
                ctrl.tag   = dir_ea ? TAG_SUB : TAG_ADD;
                ctrl.x_upd = 1'b1;
                ctrl.asel  = SA_EA;
                ctrl.bsel  = SB_QUICK;
                ctrl.dest  = DST_EA;
                if (an_target) begin
                    ctrl.size = SZ_LONG;
                end
            end
            GRP_NEG: begin
                ctrl.op    = ALU_SUB;
                ctrl.tag   = TAG_SUB;
                ctrl.x_upd = 1'b1;
                ctrl.asel  = SA_ZERO;
                ctrl.bsel  = SB_EA;
                ctrl.dest  = DST_EA;
            end
            GRP_NOT: begin
                ctrl.op   = ALU_NOT;
                ctrl.tag  = TAG_LOGIC;
                ctrl.asel = SA_EA;
                ctrl.bsel = SB_EA;
                ctrl.dest = DST_EA;
            end
            default: ctrl.legal = 1'b0;
        endcase
        if (ctrl.size == SZ_BAD) begin
            ctrl.legal = 1'b0;
        end
        if (!ctrl.legal) begin
            ctrl = '0;
        end
    end
endmodule

// File: rtl/sie_alu.sv
// Sized ALU: masks both operands to the selected size, computes the
// operation, and reports the extend (carry/borrow) condition.
// Assumes operand a is minuend/left side, b is source. Combinational.
module sie_alu
    import sie_pkg::*;
(
    input  alu_e              op,
    input  size_e             size,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] src_sized,
    output logic [DATA_W-1:0] res,
    output logic              xo
);
    logic [DATA_W-1:0] m;
    logic [DATA_W-1:0] am;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] dif;

    assign m         = size_mask(size);
    assign am        = a & m;
    assign src_sized = b & m;
    assign sum       = (am + src_sized) & m;
    assign dif       = (am - src_sized) & m;

    // Select the operation result and its extend condition.
    always_comb begin
        xo = 1'b0;
        case (op)
            ALU_ADD: begin res = sum; xo = (sum < src_sized); end
            ALU_SUB: begin res = dif; xo = (am < src_sized); end
            ALU_AND: res = am & src_sized;
            ALU_OR:  res = am | src_sized;
            ALU_XOR: res = am ^ src_sized;
            default: res = ~am & m;
        endcase
    end
endmodule

// File: rtl/sie_wb.sv
// Write-back former: merges the sized result into the old register value
// for data-register destinations, zero-extends it for effective-address
// destinations, and produces the replaced-lane mask. Combinational.
module sie_wb
    import sie_pkg::*;
(
    input  dest_e             dest,
    input  size_e             size,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] reg_old,
    output logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  mask
);
    logic [LANES-1:0] lm;
    logic             keep_old;
    logic             active;

    assign lm       = lane_mask(size);
    assign keep_old = (dest == DST_DREG);
    assign active   = (dest != DST_NONE);
    assign mask     = active ? lm : '0;

    // One multiplexer per byte lane: new byte, old byte or zero.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign data[8*i +: 8] = (active && lm[i]) ? res[8*i +: 8] :
                                keep_old          ? reg_old[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/sie_exec.sv
// Top of the sized integer execute unit. Decodes the instruction, selects
// operands (register, effective address, immediate, quick constant, zero),
// runs the sized ALU, forms the write-back, and registers every output on
// start. Assumes one instruction in flight; inputs valid in the start cycle.
module sie_exec
    import sie_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [GRP_W-1:0]  group,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] reg_in,
    input  logic [DATA_W-1:0] ea_in,
    input  logic [EXT_W-1:0]  ext0,
    input  logic [EXT_W-1:0]  ext1,
    output logic              done,
    output logic              err,
    output logic [1:0]        wb_dest,
    output logic [DATA_W-1:0] wb_data,
    output logic [LANES-1:0]  wb_mask,
    output logic [1:0]        flag_tag,
    output logic [1:0]        flag_size,
    output logic [DATA_W-1:0] cc_result,
    output logic [DATA_W-1:0] cc_source,
    output logic              x_flag,
    output logic [2:0]        ext_bytes
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] imm_val;
    logic [DATA_W-1:0] quick_val;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] src_sized;
    logic [DATA_W-1:0] alu_res;
    logic              alu_x;
    logic [DATA_W-1:0] wb_data_c;
    logic [LANES-1:0]  wb_mask_c;
    logic [3:0]        quick_cnt;
    logic              unused_opc_bits;

    assign unused_opc_bits = ^{opcode[OPC_W-1:12], opcode[2:0]};

    sie_decode u_dec (
        .group (group),
        .fld   (opcode[11:3]),
        .ctrl  (ctrl)
    );

    // Immediate: one extension word for byte/word, two for long.
    assign imm_val   = (ctrl.size == SZ_LONG) ? DATA_W'({ext0, ext1}) : DATA_W'(ext0);
    // Quick constant: field value 0 stands for 8.
    assign quick_cnt = (opcode[11:9] == 3'd0) ? 4'd8 : {1'b0, opcode[11:9]};
    assign quick_val = {{(DATA_W-4){1'b0}}, quick_cnt};

    // Left operand selection.
    always_comb begin
        case (ctrl.asel)
            SA_REG:  opa = reg_in;
            SA_EA:   opa = ea_in;
            default: opa = '0;
        endcase
    end

    // Right (source) operand selection.
    always_comb begin
        case (ctrl.bsel)
            SB_REG:  opb = reg_in;
            SB_EA:   opb = ea_in;
            SB_IMM:  opb = imm_val;
            default: opb = quick_val;
        endcase
    end

    sie_alu u_alu (
        .op        (ctrl.op),
        .size      (ctrl.size),
        .a         (opa),
        .b         (opb),
        .src_sized (src_sized),
        .res       (alu_res),
        .xo        (alu_x)
    );

    sie_wb u_wb (
        .dest    (ctrl.dest),
        .size    (ctrl.size),
        .res     (alu_res),
        .reg_old (reg_in),
        .data    (wb_data_c),
        .mask    (wb_mask_c)
    );

    // Completion strobe: one cycle after each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= start;
        end
    end

    // Result registers: captured on start, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err       <= 1'b0;
            wb_dest   <= 2'd0;
            wb_data   <= '0;
            wb_mask   <= '0;
            flag_tag  <= 2'd0;
            flag_size <= 2'd0;
            cc_result <= '0;
            cc_source <= '0;
            ext_bytes <= 3'd0;
        end else if (start) begin
            err       <= !ctrl.legal;
            wb_dest   <= ctrl.dest;
            wb_data   <= wb_data_c;
            wb_mask   <= wb_mask_c;
            flag_tag  <= ctrl.tag;
            flag_size <= ctrl.size;
            cc_result <= (ctrl.tag != TAG_NONE) ? alu_res : '0;
            cc_source <= (ctrl.tag == TAG_ADD || ctrl.tag == TAG_SUB) ? src_sized : '0;
            ext_bytes <= ctrl.ext_bytes;
        end
    end

    // Extend flag: updated only by arithmetic that defines it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_flag <= 1'b0;
        end else if (start && ctrl.x_upd) begin
            x_flag <= alu_x;
        end
    end
endmodule

// File: rtl/sie_exec_chk.sv
// Property checker for sie_exec, attached with bind. Observes ports only.
module sie_exec_chk
    import sie_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] reg_in,
    input logic              done,
    input logic              err,
    input logic [1:0]        wb_dest,
    input logic [DATA_W-1:0] wb_data,
    input logic [LANES-1:0]  wb_mask,
    input logic [1:0]        flag_tag,
    input logic [1:0]        flag_size,
    input logic              x_flag,
    input logic [2:0]        ext_bytes
);
    // R12: completion follows start by one cycle
    a_r12_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R12: no completion without a start
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R1: illegal instructions leave no effect
    a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (wb_dest == 2'd0 && wb_mask == '0 && flag_tag == 2'd0
                           && ext_bytes == 3'd0 && $stable(x_flag)));

    // R2: a byte write to a data register keeps the upper bits
    a_r2_byte_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wb_dest == 2'd1 && wb_mask == 4'b0001) |->
            (wb_data[DATA_W-1:8] == $past(reg_in[DATA_W-1:8])));

    // R2: a word write to a data register keeps the upper bits
    a_r2_word_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wb_dest == 2'd1 && wb_mask == 4'b0011) |->
            (wb_data[DATA_W-1:16] == $past(reg_in[DATA_W-1:16])));

    // R2: lane mask is always a contiguous low run when writing
    a_r2_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wb_dest != 2'd0) |->
            (wb_mask == 4'b0001 || wb_mask == 4'b0011 || wb_mask == 4'b1111));

    // R11: logic operations keep the extend flag
    a_r11_logic_keeps_x: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_tag == 2'd1) |-> $stable(x_flag));

    // R9: compares (subtract tag, no write-back) keep the extend flag
    a_r9_compare_keeps_x: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_tag == 2'd3 && wb_dest == 2'd0) |-> $stable(x_flag));

    // R6: a four-byte immediate only occurs at long size
    a_r6_long_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ext_bytes == 3'd4) |-> (flag_size == 2'd2));
endmodule

bind sie_exec sie_exec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .reg_in    (reg_in),
    .done      (done),
    .err       (err),
    .wb_dest   (wb_dest),
    .wb_data   (wb_data),
    .wb_mask   (wb_mask),
    .flag_tag  (flag_tag),
    .flag_size (flag_size),
    .x_flag    (x_flag),
    .ext_bytes (ext_bytes)
);

// File: tb/sim_sie_exec.sv
module sim_sie_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  group = '0;
    logic [15:0] opcode = '0;
    logic [31:0] reg_in = '0;
    logic [31:0] ea_in = '0;
    logic [15:0] ext0 = '0;
    logic [15:0] ext1 = '0;
    logic        done, err, x_flag;
    logic [1:0]  wb_dest, flag_tag, flag_size;
    logic [31:0] wb_data, cc_result, cc_source;
    logic [3:0]  wb_mask;
    logic [2:0]  ext_bytes;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // expected values from the behavioural model
    bit          e_err, e_x;
    int          e_dest, e_tag, e_size, e_ext;
    logic [31:0] e_data, e_res, e_src;
    logic [3:0]  e_mask;

    always #2 clk = ~clk;

    sie_exec u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .group(group), .opcode(opcode),
        .reg_in(reg_in), .ea_in(ea_in), .ext0(ext0), .ext1(ext1),
        .done(done), .err(err), .wb_dest(wb_dest), .wb_data(wb_data),
        .wb_mask(wb_mask), .flag_tag(flag_tag), .flag_size(flag_size),
        .cc_result(cc_result), .cc_source(cc_source), .x_flag(x_flag),
        .ext_bytes(ext_bytes)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int sub, input int dir, input int sz, input int mode);
        logic [15:0] w;
        w = 16'h0;
        w[11:9] = 3'(sub);
        w[8]    = 1'(dir);
        w[7:6]  = 2'(sz);
        w[5:3]  = 3'(mode);
        return w;
    endfunction

    // Behavioural reference: computes every expected output.
    task automatic model(input int g, input logic [15:0] op, input logic [31:0] rv,
                         input logic [31:0] ev, input logic [15:0] w0, input logic [15:0] w1);
        int sz, kind, dest, eb, nbytes;
        bit ok, xu;
        longint unsigned msk, a, b, r;
        bit xv;
        sz = int'(op[7:6]); ok = 1; dest = 0; eb = 0; xu = 0; kind = 0;
        a = 0; b = 0; r = 0; xv = 0;
        case (g)
            0, 1, 2, 3: begin
                kind = g;
                xu = (g < 2);
                if (op[8]) begin a = ev; b = rv; dest = 2; end
                else       begin a = rv; b = ev; dest = 1; end
            end
            4: begin kind = 4; a = ev; b = rv; dest = 2; end
            5: begin kind = 1; a = rv; b = ev; dest = 0; end
            6: begin
                a = ev; dest = 2;
                b = (sz == 2) ? {w0, w1} : {16'h0, w0};
                eb = (sz == 2) ? 4 : 2;
                case (int'(op[11:9]))
                    0: kind = 3;
                    1: kind = 2;
                    2: begin kind = 1; xu = 1; end
                    3: begin kind = 0; xu = 1; end
                    5: kind = 4;
                    6: begin kind = 1; dest = 0; end
                    default: ok = 0;
                endcase
            end
            7: begin
                kind = op[8] ? 1 : 0; xu = 1; a = ev; dest = 2;
                b = (op[11:9] == 3'd0) ? 8 : longint'(op[11:9]);
                if (op[5:3] == 3'b001) sz = 2;
            end
            8: begin kind = 1; xu = 1; a = 0; b = ev; dest = 2; end
            9: begin kind = 5; a = ev; dest = 2; end
            default: ok = 0;
        endcase
        if (sz == 3) ok = 0;
        nbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        msk = (64'd1 << (8 * nbytes)) - 1;
        a = a & msk; b = b & msk;
        case (kind)
            0: begin r = (a + b) & msk; xv = (r < b); e_tag = 2; end
            1: begin r = (a - b) & msk; xv = (a < b); e_tag = 3; end
            2: begin r = a & b; e_tag = 1; end
            3: begin r = a | b; e_tag = 1; end
            4: begin r = a ^ b; e_tag = 1; end
            default: begin r = (~a) & msk; e_tag = 1; end
        endcase
        if (!ok) begin
            e_err = 1; e_dest = 0; e_data = 0; e_mask = 0; e_tag = 0; e_size = 0;
            e_res = 0; e_src = 0; e_ext = 0;
        end else begin
            e_err  = 0;
            e_dest = dest;
            e_size = sz;
            e_ext  = eb;
            e_res  = 32'(r);
            e_src  = (e_tag >= 2) ? 32'(b) : 32'h0;
            e_mask = (dest == 0) ? 4'h0 : 4'((1 << nbytes) - 1);
            if (dest == 1)      e_data = (rv & ~32'(msk)) | 32'(r);
            else if (dest == 2) e_data = 32'(r);
            else                e_data = 32'h0;
            if (xu) e_x = xv;
        end
    endtask

    // Issue one instruction, compare all outputs, then confirm the pulse ends and results hold.
    task automatic issue(input string req, input int g, input logic [15:0] op, input logic [31:0] rv,
                         input logic [31:0] ev, input logic [15:0] w0, input logic [15:0] w1);
        model(g, op, rv, ev, w0, w1);
        @(negedge clk);
        group = 4'(g); opcode = op; reg_in = rv; ea_in = ev; ext0 = w0; ext1 = w1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12", "done",      32'(done),      32'd1);
        chk(req,   "err",       32'(err),       32'(e_err));
        chk(req,   "wb_dest",   32'(wb_dest),   32'(e_dest));
        chk(req,   "wb_data",   wb_data,        e_data);
        chk(req,   "wb_mask",   32'(wb_mask),   32'(e_mask));
        chk(req,   "flag_tag",  32'(flag_tag),  32'(e_tag));
        chk(req,   "flag_size", 32'(flag_size), 32'(e_size));
        chk(req,   "cc_result", cc_result,      e_res);
        chk(req,   "cc_source", cc_source,      e_src);
        chk(req,   "x_flag",    32'(x_flag),    32'(e_x));
        chk(req,   "ext_bytes", 32'(ext_bytes), 32'(e_ext));
        reg_in = ~rv; ea_in = ~ev;
        @(negedge clk);
        chk("R12", "done low", 32'(done),  32'd0);
        chk("R12", "held",     wb_data,    e_data);
        chk("R12", "x held",   32'(x_flag), 32'(e_x));
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        e_x = 0;
        repeat (3) @(negedge clk);
        chk("R12", "reset done",   32'(done),    32'd0);
        chk("R1",  "reset err",    32'(err),     32'd0);
        chk("R10", "reset x",      32'(x_flag),  32'd0);
        chk("R2",  "reset wbdest", 32'(wb_dest), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R2: byte add into data register with carry out of the byte
        issue("R10", 0, mk(1, 0, 0, 0), 32'h123456F0, 32'h00000020, 16'h0, 16'h0);
        // R3: word add toward the effective address
        issue("R3",  0, mk(1, 1, 1, 2), 32'h00001234, 32'hAAAA0010, 16'h0, 16'h0);
        // R10: long subtract with borrow
        issue("R10", 1, mk(2, 0, 2, 0), 32'h00000005, 32'h00000007, 16'h0, 16'h0);
        // R2: word subtract into data register, upper half kept
        issue("R2",  1, mk(2, 0, 1, 0), 32'hDEAD0005, 32'h00000003, 16'h0, 16'h0);
        // R3: subtract toward EA reverses operand order
        issue("R3",  1, mk(2, 1, 0, 2), 32'h00000001, 32'h00000010, 16'h0, 16'h0);
        // R11: byte and into register, extend kept
        issue("R11", 2, mk(0, 0, 0, 0), 32'hFFFFFF0F, 32'h0000003C, 16'h0, 16'h0);
        // R11: word or toward EA
        issue("R11", 3, mk(0, 1, 1, 2), 32'h00000F00, 32'h123400F0, 16'h0, 16'h0);
        // R3: exclusive-or long
        issue("R3",  4, mk(0, 0, 2, 2), 32'hFFFF0000, 32'h12345678, 16'h0, 16'h0);
        // R9: byte compare, no write-back, extend kept
        issue("R9",  5, mk(3, 0, 0, 0), 32'h00000010, 32'h00000020, 16'h0, 16'h0);
        // R6: byte immediate add uses low byte of first extension word
        issue("R6",  6, mk(3, 0, 0, 2), 32'h0, 32'h000000F0, 16'hAB12, 16'hFFFF);
        // R6: long immediate subtract uses both words
        issue("R6",  6, mk(2, 0, 2, 2), 32'h0, 32'h00010005, 16'h0001, 16'h0007);
        // R7: word immediate compare, no write-back
        issue("R7",  6, mk(6, 0, 1, 2), 32'h0, 32'h00000100, 16'h0200, 16'h0);
        // R7: immediate or, exclusive-or, and
        issue("R7",  6, mk(0, 0, 0, 2), 32'h0, 32'h00000011, 16'h5588, 16'h0);
        issue("R7",  6, mk(5, 0, 1, 2), 32'h0, 32'h0000FFFF, 16'h0F0F, 16'h0);
        issue("R7",  6, mk(1, 0, 2, 2), 32'h0, 32'hF0F0F0F0, 16'hFF00, 16'h00FF);
        // R7: illegal immediate operation codes
        issue("R7",  6, mk(4, 0, 0, 2), 32'h0, 32'h00000001, 16'h0001, 16'h0);
        issue("R7",  6, mk(7, 0, 1, 2), 32'h0, 32'h00000001, 16'h0001, 16'h0);
        // R4: quick add with field 0 meaning 8
        issue("R4",  7, mk(0, 0, 0, 2), 32'h0, 32'h000000FC, 16'h0, 16'h0);
        // R4: quick subtract of 3 at word size
        issue("R4",  7, mk(3, 1, 1, 2), 32'h0, 32'h00000002, 16'h0, 16'h0);
        // R5: quick add to address register is long even with byte size
        issue("R5",  7, mk(1, 0, 0, 1), 32'h0, 32'h000000FF, 16'h0, 16'h0);
        // R5: quick to address register with size code 3 is legal
        issue("R5",  7, mk(2, 1, 3, 1), 32'h0, 32'h00000001, 16'h0, 16'h0);
        // R1: plain add with size code 3 is illegal
        issue("R1",  0, mk(1, 0, 3, 0), 32'h00000001, 32'h00000001, 16'h0, 16'h0);
        // R8: negate of zero clears extend, negate of one sets it
        issue("R8",  8, mk(0, 0, 1, 2), 32'h0, 32'hABCD0000, 16'h0, 16'h0);
        issue("R8",  8, mk(0, 0, 0, 2), 32'h0, 32'h00000001, 16'h0, 16'h0);
        // R11: not at long size
        issue("R11", 9, mk(0, 0, 2, 2), 32'h0, 32'h0F0F1234, 16'h0, 16'h0);
        // R13: undefined group code
        issue("R13", 12, mk(1, 0, 0, 0), 32'h1, 32'h1, 16'h0, 16'h0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule